// File: doc/BRIEF.md
# Banked Blocked Texel Cache

This is a read-only cache for texture samplers. It returns the four texels of a 2x2 bilinear footprint in one cycle. A request carries integer texel coordinates (u, v), a mipmap level and the line address of that level's image. The block names the covered texels (u,v), (u+1,v), (u,v+1) and (u+1,v+1). When every tile those texels fall in is resident, the request is accepted and the four 32-bit RGBA words appear on the response port one cycle later.

Images are stored tiled. Each 4x4 tile of 16 texels is one cache line, and the tile size is the same at every level. Each tile touched by the footprint is tag-checked on its own. A footprint can cover one, two or four tiles. Every missing tile is brought in through a simple line-fill port, one line per fill, before the request is accepted.

Texels are spread over four storage banks by the parity of their coordinates, so the four footprint reads never meet in the same bank. The cache is 2-way set associative with one LRU bit per set. A trilinear sampler uses two instances: one serves even levels and the other serves odd levels.

Top module: `texel_cache`

## Requirements
- R1: After reset, rsp_valid_o and fill_req_o are low, and no line is valid. The first request therefore misses.
- R2: An accepted request (req_valid_i and req_ready_o high at a clock edge) sets rsp_valid_o for exactly the next cycle. rsp_texels_o bits [32k+31:32k] then hold texel k, with k=0 at (u,v), k=1 at (u+1,v), k=2 at (u,v+1) and k=3 at (u+1,v+1).
- R3: A texel (x,y) lies in tile (tx,ty) = (x>>2, y>>2). The tile's line address is req_base_i + {ty,tx}, with ty and tx each CW-2 bits wide. Inside a filled line, the texel sits in word (y mod 4)*4 + (x mod 4) of fill_data_i.
- R4: Each distinct tile of the footprint is checked separately. Missing tiles are filled one at a time, in footprint order k=0..3. The request is accepted only once all of its tiles hit.
- R5: u+1 and v+1 wrap modulo 2^CW.
- R6: fill_req_o stays high, with fill_addr_o unchanged, until the cycle in which fill_valid_i is high. No request is accepted while a fill is outstanding.
- R7: A tile maps to set {ty[1:0], tx[1:0]} (default 16 sets). Two different tiles in the same set stay resident together.
- R8: A miss replaces the least recently used way of its set. Both an accept and a fill count as a use.
- R9: A high inv_i clears every valid bit in one cycle, so later requests miss again.
- R10: The mipmap level is part of the tag. The same address under another level is a different line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| inv_i | input | 1 | Invalidate all lines |
| req_valid_i | input | 1 | Request present; held until accepted |
| req_ready_o | output | 1 | All footprint tiles hit; request accepted |
| req_u_i | input | CW | Texel column of footprint origin |
| req_v_i | input | CW | Texel row of footprint origin |
| req_lvl_i | input | LVL_W | Mipmap level |
| req_base_i | input | LA_W | Line address of the level image |
| rsp_valid_o | output | 1 | Texels valid |
| rsp_texels_o | output | 128 | Four RGBA texels, k=0 in low word |
| fill_req_o | output | 1 | Line fill requested |
| fill_addr_o | output | LA_W | Line address to fill |
| fill_valid_i | input | 1 | Fill data present this cycle |
| fill_data_i | input | 512 | 16 texels of the line, word 0 in low bits |

## Verification
The bench uses the default parameters: CW=10, which gives 256 tiles per row and lets the wrap at 1023 be reached directly, and 16 sets. With 16 sets, small coordinate ranges under two bases and four levels already collide in single sets. That collision drives the LRU, level-tag and multi-tile fill ordering paths. A behavioural model tracks tile residency and predicts every fill address and every response word on each clock.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int TEXEL_W   = 32;
  localparam int NUM_BANKS = 4;
  localparam int NUM_WAYS  = 2;
  localparam int BANK_WRDS = 4;
  localparam int LINE_TXL  = NUM_BANKS * BANK_WRDS;
  localparam int FP_TXL    = 4;
  typedef logic [TEXEL_W-1:0] texel_t;
endpackage

// File: rtl/tc_tag_array.sv
module tc_tag_array
  import tc_pkg::*;
#(
  parameter int N_SETS = 16,
  parameter int KEY_W  = 30,
  localparam int SW    = $clog2(N_SETS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       inv_i,
  input  logic [FP_TXL-1:0][SW-1:0]  q_set_i,
  input  logic [FP_TXL-1:0][KEY_W-1:0] q_key_i,
  input  logic                       touch_i,
  input  logic                       fill_en_i,
  input  logic [SW-1:0]              fill_set_i,
  input  logic                       fill_way_i,
  input  logic [KEY_W-1:0]           fill_key_i,
  output logic [FP_TXL-1:0]          hit_o,
  output logic [FP_TXL-1:0]          hit_way_o,
  output logic [FP_TXL-1:0]          victim_o
);
  logic [N_SETS-1:0][NUM_WAYS-1:0] valid_q;
  logic [N_SETS-1:0]               lru_q;
  logic [KEY_W-1:0]                key_q [N_SETS][NUM_WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      lru_q   <= '0;
    end else begin
      if (touch_i)
        for (int i = 0; i < FP_TXL; i++) lru_q[q_set_i[i]] <= ~hit_way_o[i];
      if (fill_en_i) begin
        valid_q[fill_set_i][fill_way_i] <= 1'b1;
        lru_q[fill_set_i]               <= ~fill_way_i;
      end
      if (inv_i) valid_q <= '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) key_q[fill_set_i][fill_way_i] <= fill_key_i;
  end

  for (genvar q = 0; q < FP_TXL; q++) begin : g_q
    logic [NUM_WAYS-1:0] match;
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_w
      assign match[w] = valid_q[q_set_i[q]][w] && (key_q[q_set_i[q]][w] == q_key_i[q]);
    end
    assign hit_o[q]     = |match;
    assign hit_way_o[q] = match[1];
    assign victim_o[q]  = lru_q[q_set_i[q]];

    // R7
    way_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(match));
  end

  // R9
  inv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> (valid_q == '0));

  // R4
  fill_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en_i && !inv_i) |=> valid_q[$past(fill_set_i)][$past(fill_way_i)]);
endmodule

// File: rtl/tc_bank.sv
module tc_bank
  import tc_pkg::*;
#(
  parameter int N_LINES = 32,
  localparam int LW     = $clog2(N_LINES),
  localparam int OW     = $clog2(BANK_WRDS)
) (
  input  logic                          clk_i,
  input  logic                          we_i,
  input  logic [LW-1:0]                 wline_i,
  input  logic [BANK_WRDS-1:0][TEXEL_W-1:0] wdata_i,
  input  logic [LW-1:0]                 rline_i,
  input  logic [OW-1:0]                 roff_i,
  output texel_t                        rdata_o
);
  logic [BANK_WRDS-1:0][TEXEL_W-1:0] mem_q [N_LINES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wline_i] <= wdata_i;
    rdata_o <= mem_q[rline_i][roff_i];
  end
endmodule

// File: rtl/texel_cache.sv
module texel_cache
  import tc_pkg::*;
#(
  parameter int CW     = 10,
  parameter int LVL_W  = 4,
  parameter int LA_W   = 26,
  parameter int N_SETS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  inv_i,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [CW-1:0]         req_u_i,
  input  logic [CW-1:0]         req_v_i,
  input  logic [LVL_W-1:0]      req_lvl_i,
  input  logic [LA_W-1:0]       req_base_i,
  output logic                  rsp_valid_o,
  output logic [FP_TXL*TEXEL_W-1:0] rsp_texels_o,
  output logic                  fill_req_o,
  output logic [LA_W-1:0]       fill_addr_o,
  input  logic                  fill_valid_i,
  input  logic [LINE_TXL*TEXEL_W-1:0] fill_data_i
);
  localparam int SW      = $clog2(N_SETS);
  localparam int SH      = SW / 2;
  localparam int SL      = SW - SH;
  localparam int TW      = CW - 2;
  localparam int KEY_W   = LVL_W + LA_W;
  localparam int N_LINES = N_SETS * NUM_WAYS;
  localparam int LNW     = $clog2(N_LINES);

  typedef enum logic {ST_LOOK, ST_FILL} st_e;
  st_e st_q;

  logic [CW-1:0] u1, v1;
  logic [FP_TXL-1:0][1:0]       q_lo_x, q_lo_y;
  logic [FP_TXL-1:0][SW-1:0]    q_set;
  logic [FP_TXL-1:0][KEY_W-1:0] q_key;
  logic [FP_TXL-1:0]            q_hit, q_way, q_vic;
  logic [1:0]                   miss_idx;
  logic                         all_hit, accept, fill_en;
  logic [KEY_W-1:0]             fill_key_q;
  logic [SW-1:0]                fill_set_q;
  logic                         fill_way_q;
  logic                         rsp_valid_q;
  logic [1:0]                   swz_q;
  texel_t                       bank_rd [NUM_BANKS];

  assign u1 = req_u_i + CW'(1);
  assign v1 = req_v_i + CW'(1);

  for (genvar q = 0; q < FP_TXL; q++) begin : g_fp
    logic [CW-1:0] x, y;
    logic [LA_W-1:0] la;
    assign x = q[0] ? u1 : req_u_i;
    assign y = q[1] ? v1 : req_v_i;
    // two-step address: tile from upper bits, texel from lower bits
    assign la          = req_base_i + LA_W'({y[CW-1:2], x[CW-1:2]});
    assign q_set[q]    = {y[2 +: SH], x[2 +: SL]};
    assign q_key[q]    = {req_lvl_i, la};
    assign q_lo_x[q]   = x[1:0];
    assign q_lo_y[q]   = y[1:0];
  end

  tc_tag_array #(.N_SETS(N_SETS), .KEY_W(KEY_W)) u_tags (
    .clk_i, .rst_ni, .inv_i,
    .q_set_i   (q_set),
    .q_key_i   (q_key),
    .touch_i   (accept),
    .fill_en_i (fill_en),
    .fill_set_i(fill_set_q),
    .fill_way_i(fill_way_q),
    .fill_key_i(fill_key_q),
    .hit_o     (q_hit),
    .hit_way_o (q_way),
    .victim_o  (q_vic)
  );

  assign all_hit     = &q_hit;
  assign req_ready_o = (st_q == ST_LOOK) && all_hit;
  assign accept      = req_valid_i && req_ready_o;
  assign fill_en     = (st_q == ST_FILL) && fill_valid_i;
  assign fill_req_o  = (st_q == ST_FILL);
  assign fill_addr_o = fill_key_q[LA_W-1:0];

  always_comb begin
    miss_idx = '0;
    for (int q = FP_TXL - 1; q >= 0; q--) if (!q_hit[q]) miss_idx = 2'(q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_LOOK;
      rsp_valid_q <= 1'b0;
      swz_q       <= '0;
      fill_key_q  <= '0;
      fill_set_q  <= '0;
      fill_way_q  <= 1'b0;
    end else begin
      rsp_valid_q <= accept;
      swz_q       <= {req_v_i[0], req_u_i[0]};
      unique case (st_q)
        ST_LOOK: if (req_valid_i && !all_hit) begin
          st_q       <= ST_FILL;
          fill_key_q <= q_key[miss_idx];
          fill_set_q <= q_set[miss_idx];
          fill_way_q <= q_vic[miss_idx];
        end
        ST_FILL: if (fill_valid_i) st_q <= ST_LOOK;
        default: st_q <= ST_LOOK;
      endcase
    end
  end

  // bank = {y[0],x[0]}, word in bank = {y[1],x[1]}
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_WRDS-1:0][TEXEL_W-1:0] wdata;
    logic [1:0]     qs;
    logic [LNW-1:0] rline;
    logic [1:0]     roff;
    for (genvar o = 0; o < BANK_WRDS; o++) begin : g_w
      localparam int IDX = (o / 2) * 8 + (b / 2) * 4 + (o % 2) * 2 + (b % 2);
      assign wdata[o] = fill_data_i[IDX*TEXEL_W +: TEXEL_W];
    end
    assign qs    = 2'(b) ^ {req_v_i[0], req_u_i[0]};
    assign rline = {q_set[qs], q_way[qs]};
    assign roff  = {q_lo_y[qs][1], q_lo_x[qs][1]};

    tc_bank #(.N_LINES(N_LINES)) u_bank (
      .clk_i,
      .we_i   (fill_en),
      .wline_i({fill_set_q, fill_way_q}),
      .wdata_i(wdata),
      .rline_i(rline),
      .roff_i (roff),
      .rdata_o(bank_rd[b])
    );
  end

  for (genvar k = 0; k < FP_TXL; k++) begin : g_out
    assign rsp_texels_o[k*TEXEL_W +: TEXEL_W] = bank_rd[2'(k) ^ swz_q];
  end
  assign rsp_valid_o = rsp_valid_q;

  // R6
  fill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_valid_i) |=> (fill_req_o && $stable(fill_addr_o)));

  // R4
  fill_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fill_req_o) |-> $past(req_valid_i));
endmodule

// File: tb/tb_texel_cache.sv
module tb_texel_cache;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inv = 1'b0;
  logic req_valid = 1'b0;
  logic [9:0] req_u = '0, req_v = '0;
  logic [3:0] req_lvl = '0;
  logic [25:0] req_base = '0;
  logic fill_valid = 1'b0;
  logic [511:0] fill_data = '0;
  logic req_ready, rsp_valid, fill_req;
  logic [127:0] rsp_texels;
  logic [25:0] fill_addr;

  int compared = 0, mismatched = 0;
  longint mk [16][2];
  bit     mv [16][2];
  int     mlru [16];
  int     exp_fill [$];
  logic [127:0] exp_rsp [$];

  always #4 clk = ~clk;

  texel_cache dut (
    .clk_i(clk), .rst_ni(rst_n), .inv_i(inv),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_u_i(req_u), .req_v_i(req_v), .req_lvl_i(req_lvl), .req_base_i(req_base),
    .rsp_valid_o(rsp_valid), .rsp_texels_o(rsp_texels),
    .fill_req_o(fill_req), .fill_addr_o(fill_addr),
    .fill_valid_i(fill_valid), .fill_data_i(fill_data)
  );

  function automatic logic [31:0] tex(int la, int idx);
    return ((32'(la) << 4) | 32'(idx)) ^ 32'h5A00_0000;
  endfunction

  function automatic logic [511:0] line_of(int la);
    logic [511:0] d;
    for (int i = 0; i < 16; i++) d[32*i +: 32] = tex(la, i);
    return d;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference: residency per set, LRU victim, expected fills and texels
  task automatic do_req(input int u, input int v, input int lvl, input int base, input string req);
    int uq, vq, tx, ty, s, la, way;
    longint key;
    int hw [4];
    int hs [4];
    logic [127:0] e;
    for (int q = 0; q < 4; q++) begin
      uq  = (u + (q & 1)) & 1023;
      vq  = (v + (q >> 1)) & 1023;
      tx  = uq >> 2;
      ty  = vq >> 2;
      la  = (base + ty * 256 + tx) & 32'h03FF_FFFF;
      s   = (ty & 3) * 4 + (tx & 3);
      key = (longint'(lvl) << 26) | longint'(la);
      way = -1;
      for (int w = 0; w < 2; w++) if (mv[s][w] && mk[s][w] == key) way = w;
      if (way < 0) begin
        way = mlru[s];
        exp_fill.push_back(la);
        mk[s][way] = key;
        mv[s][way] = 1'b1;
        mlru[s] = 1 - way;
      end
      hw[q] = way;
      hs[q] = s;
      e[32*q +: 32] = tex(la, (vq & 3) * 4 + (uq & 3));
    end
    for (int q = 0; q < 4; q++) mlru[hs[q]] = 1 - hw[q];
    @(negedge clk);
    req_valid = 1'b1; req_u = 10'(u); req_v = 10'(v); req_lvl = 4'(lvl); req_base = 26'(base);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    exp_rsp.push_back(e);
    chk({req, " fills outstanding at accept"}, 128'(exp_fill.size()), 128'd0);
    exp_fill.delete();
  endtask

  // memory responder: R3 address check, R6 handshake
  initial begin
    forever begin
      @(negedge clk);
      if (fill_req) begin
        if (exp_fill.size() == 0) chk("R4 unexpected fill", 128'(fill_addr), 128'h0);
        else chk("R3 fill address", 128'(fill_addr), 128'(exp_fill.pop_front()));
        repeat (LAT) @(negedge clk);
        chk("R6 fill_req held", 128'(fill_req), 128'd1);
        fill_valid = 1'b1;
        fill_data  = line_of(int'(fill_addr));
        @(negedge clk);
        fill_valid = 1'b0;
      end
    end
  end

  // per-clock response comparison: R2
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (rsp_valid) begin
          if (exp_rsp.size() == 0) chk("R2 unexpected rsp_valid", 128'd1, 128'd0);
          else chk("R2 texels", rsp_texels, exp_rsp.pop_front());
        end else if (exp_rsp.size() != 0) begin
          chk("R2 missing rsp_valid", 128'd0, 128'd1);
          exp_rsp.delete();
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int seed;
    for (int s = 0; s < 16; s++) begin
      mlru[s] = 0;
      for (int w = 0; w < 2; w++) begin mv[s][w] = 1'b0; mk[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 128'(rsp_valid), 128'd0);
    chk("R1 fill_req", 128'(fill_req), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready while idle", 128'(req_ready), 128'd0);

    do_req(5, 6, 0, 'h1000, "R1 R3 first miss");
    do_req(5, 6, 0, 'h1000, "R2 repeat hit");
    do_req(3, 3, 0, 'h1000, "R4 four tiles");
    do_req(7, 2, 0, 'h1000, "R4 two tiles");
    do_req(1023, 1023, 0, 'h1000, "R5 wrap");
    do_req(5, 6, 1, 'h1000, "R10 other level");
    do_req(5, 6, 0, 'h1000, "R7 both resident");
    do_req(5, 6, 2, 'h1000, "R8 evict lru");
    do_req(5, 6, 0, 'h1000, "R8 mru kept");
    do_req(5, 6, 1, 'h1000, "R8 lru refetched");

    // R9 invalidate
    @(negedge clk); inv = 1'b1;
    @(negedge clk); inv = 1'b0;
    for (int s = 0; s < 16; s++) for (int w = 0; w < 2; w++) mv[s][w] = 1'b0;
    do_req(5, 6, 0, 'h1000, "R9 refill after invalidate");

    seed = 12345;
    for (int i = 0; i < 80; i++) begin
      seed = seed * 1103515245 + 12345;
      do_req((seed >> 4) & 31, (seed >> 10) & 31, (seed >> 16) & 3,
             ((seed >> 20) & 1) ? 'h2000 : 'h1000, "R4 R8 mixed");
    end
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule